// File: doc/BRIEF.md
# Consecutive-Sample Debounce Filter

This block cleans up a single-bit input that may chatter. It keeps a confirmed output level and moves to the opposite level only after that level has been seen on a set number of consecutive accepted samples. The run length is the parameter `RUN_LEN`, with a default of 3. The change is Mealy-timed: the output takes the new level in the same cycle as the sample that completes the run, not one cycle later.

Samples enter on a valid-only stream. A sample is taken on each clock edge where `smp_valid` is high. There is no ready signal, because the filter accepts every offered sample and never applies back-pressure. Cycles with `smp_valid` low are gaps: they neither break nor extend a run, and the output and run state stay frozen. The input is expected to be synchronised already, and the sample strobe is generated outside the block.

A registered one-cycle pulse reports each change of the confirmed level. A synchronous reset sets the confirmed level to 1. After reset the run tracker behaves as if one sample of 1 had already been seen.

Top module: `run_debounce`

## Requirements
- R1: In the first cycle after synchronous reset, `level_out` is 1 and `level_changed` is 0.
- R2: While `smp_valid` is low, `level_out` does not change and `smp_bit` is ignored. Accepted samples separated by such gaps still count as consecutive.
- R3: When an accepted sample completes `RUN_LEN` consecutive equal samples, `level_out` shows that sample's level combinationally in the same cycle. It keeps that level until a complete run of the opposite level arrives.
- R4: A run of the opposite level that is shorter than `RUN_LEN` and then broken by a differing sample leaves `level_out` unchanged. Counting restarts at 1 for the new level.
- R5: With `RUN_LEN` = 3, starting from reset, the accepted samples 1,0,0,1,0,1,0,0,0,1,0,1,1,1 give `level_out` values 1,1,1,1,1,1,1,1,0,0,0,0,0,1 on those same samples.
- R6: `level_changed` is high for exactly the one cycle that follows a cycle in which `level_out` differed from the previously confirmed level. It is low otherwise.
- R7: The run count saturates. An arbitrarily long run of one level holds the output without wrapping. Returning to the other level still needs a full `RUN_LEN` run.
- R8: A reset asserted while the confirmed level is 0 returns `level_out` to 1.
- R9: `RUN_LEN` may be any value of 2 or more. For `RUN_LEN` = 2, two equal accepted samples are enough to switch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample strobe. `smp_bit` is taken on edges where this is high. |
| smp_bit | input | 1 | Raw, already synchronised input bit |
| level_out | output | 1 | Confirmed (filtered) level, Mealy-timed |
| level_changed | output | 1 | Registered one-cycle pulse after each change of the confirmed level |

## Verification
The bench builds two copies of the filter and drives both with the same stimulus: one with the default run length of 3 and one with the minimum of 2. The length-3 copy is checked against the fixed sample vector and against interrupted runs that stop one sample short. The length-2 copy reaches the boundary where the saturating counter is only two values wide, and where a single repeated sample already flips the output. Long same-level runs, strobe gaps with a toggling input, and mid-run resets are compared against a behavioural model on every cycle.

// File: rtl/dbf_pkg.sv
package dbf_pkg;
  // Confirmed level and last-seen sample after reset
  localparam logic RESET_LEVEL = 1'b1;
  // Smallest run length the filter supports
  localparam int MIN_RUN_LEN = 2;
endpackage

// File: rtl/dbf_run_tracker.sv
// Tracks the length of the current run of equal accepted samples and
// flags the sample that completes (or extends) a full run.
module dbf_run_tracker #(
  parameter int RUN_LEN = 3,
  parameter int CNT_W   = $clog2(RUN_LEN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic bit_in,
  output logic run_hit
);
  import dbf_pkg::*;

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RUN_LEN);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic             last_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (bit_in != last_q)   cnt_d = ONE;
    else if (cnt_q >= LIMIT) cnt_d = LIMIT;
    else                     cnt_d = cnt_q + ONE;
  end

  assign run_hit = take && (cnt_d == LIMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= RESET_LEVEL;
      cnt_q  <= ONE;
    end else if (take) begin
      last_q <= bit_in;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/dbf_level_hold.sv
// Holds the confirmed level; passes a completed run's level straight through.
module dbf_level_hold (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic bit_in,
  input  logic run_hit,
  output logic level,
  output logic flip
);
  import dbf_pkg::*;

  logic held_q;

  assign level = run_hit ? bit_in : held_q;
  assign flip  = level != held_q;

  always_ff @(posedge clk) begin
    if (rst)       held_q <= RESET_LEVEL;
    else if (take) held_q <= level;
  end
endmodule

// File: rtl/dbf_change_pulse.sv
// Registers the level-change indication into a one-cycle pulse.
module dbf_change_pulse (
  input  logic clk,
  input  logic rst,
  input  logic flip,
  output logic pulse
);
  always_ff @(posedge clk) begin
    if (rst) pulse <= 1'b0;
    else     pulse <= flip;
  end
endmodule

// File: rtl/run_debounce.sv
module run_debounce #(
  parameter int RUN_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic smp_valid,
  input  logic smp_bit,
  output logic level_out,
  output logic level_changed
);
  localparam int CNT_W = $clog2(RUN_LEN + 1);

  logic run_hit;
  logic flip;

  dbf_run_tracker #(.RUN_LEN(RUN_LEN), .CNT_W(CNT_W)) u_trk (
    .clk     (clk),
    .rst     (rst),
    .take    (smp_valid),
    .bit_in  (smp_bit),
    .run_hit (run_hit)
  );

  dbf_level_hold u_hold (
    .clk     (clk),
    .rst     (rst),
    .take    (smp_valid),
    .bit_in  (smp_bit),
    .run_hit (run_hit),
    .level   (level_out),
    .flip    (flip)
  );

  dbf_change_pulse u_pls (
    .clk   (clk),
    .rst   (rst),
    .flip  (flip),
    .pulse (level_changed)
  );
endmodule

// File: rtl/dbf_checker.sv
module dbf_checker #(
  parameter int RUN_LEN = 3
) (
  input logic clk,
  input logic rst,
  input logic smp_valid,
  input logic smp_bit,
  input logic level_out,
  input logic level_changed
);
  logic rst_q  = 1'b1;
  logic rst_qq = 1'b1;
  logic lvl_q  = 1'b1;
  logic lvl_qq = 1'b1;
  logic last_c = 1'b1;
  int   run_c  = 1;
  int   run_now;

  always_comb run_now = (smp_bit == last_c) ? run_c + 1 : 1;

  always_ff @(posedge clk) begin
    rst_q  <= rst;
    rst_qq <= rst_q;
    lvl_q  <= level_out;
    lvl_qq <= lvl_q;
    if (rst) begin
      last_c <= 1'b1;
      run_c  <= 1;
    end else if (smp_valid) begin
      last_c <= smp_bit;
      run_c  <= (run_now > RUN_LEN) ? RUN_LEN : run_now;
    end
  end

  assert_reset_level_R1: assert property (@(posedge clk) disable iff (rst)
    rst_q |-> (level_out && !level_changed));

  assert_frozen_gap_R2: assert property (@(posedge clk) disable iff (rst)
    (!rst_q && !smp_valid) |-> (level_out == lvl_q));

  assert_flip_on_sample_R3: assert property (@(posedge clk) disable iff (rst)
    (!rst_q && level_out != lvl_q) |-> (smp_valid && smp_bit == level_out));

  assert_flip_needs_run_R4: assert property (@(posedge clk) disable iff (rst)
    (!rst_q && level_out != lvl_q) |-> (run_now >= RUN_LEN));

  assert_pulse_follows_R6: assert property (@(posedge clk) disable iff (rst)
    (!rst_q && !rst_qq) |-> (level_changed == (lvl_q != lvl_qq)));
endmodule

bind run_debounce dbf_checker #(.RUN_LEN(RUN_LEN)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .smp_valid     (smp_valid),
  .smp_bit       (smp_bit),
  .level_out     (level_out),
  .level_changed (level_changed)
);

// File: tb/sim_run_debounce.sv
`timescale 1ns/1ps
module sim_run_debounce;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_valid = 1'b0;
  logic smp_bit = 1'b0;
  logic out0, out1, pls0, pls1;

  always #2.5 clk = ~clk;

  run_debounce #(.RUN_LEN(3)) u0 (.clk(clk), .rst(rst), .smp_valid(smp_valid),
    .smp_bit(smp_bit), .level_out(out0), .level_changed(pls0));
  run_debounce #(.RUN_LEN(2)) u1 (.clk(clk), .rst(rst), .smp_valid(smp_valid),
    .smp_bit(smp_bit), .level_out(out1), .level_changed(pls1));

  int n_run = 0, n_fail = 0;
  bit done = 0;
  int rl[2] = '{3, 2};
  int m_last[2], m_run[2], m_held[2], m_pulse[2];

  task automatic chk(int got, int exp, string tag);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: got %0d expected %0d", tag, $time, got, exp);
    end
  endtask

  function automatic int next_run(int i, bit d);
    int r;
    if (d != m_last[i]) return 1;
    r = m_run[i] + 1;
    return (r > rl[i]) ? rl[i] : r;
  endfunction

  function automatic int exp_out(int i, bit en, bit d);
    if (!en) return m_held[i];
    return (next_run(i, d) >= rl[i]) ? int'(d) : m_held[i];
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      m_last[i] = 1; m_run[i] = 1; m_held[i] = 1; m_pulse[i] = 0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; smp_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  // Drive one cycle, compare both copies against the model, then advance it.
  task automatic step(bit en, bit d, string tag);
    int e, g, gp;
    @(negedge clk);
    smp_valid = en; smp_bit = d;
    #1;
    for (int i = 0; i < 2; i++) begin
      e  = exp_out(i, en, d);
      g  = (i == 0) ? int'(out0) : int'(out1);
      gp = (i == 0) ? int'(pls0) : int'(pls1);
      chk(g, e, tag);
      chk(gp, m_pulse[i], "R6");
      if (en) begin
        m_pulse[i] = (e != m_held[i]) ? 1 : 0;
        m_run[i]   = next_run(i, d);
        m_last[i]  = d;
        m_held[i]  = e;
      end else begin
        m_pulse[i] = 0;
      end
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [13:0] vin, vexp;
    logic [15:0] lfsr;
    model_reset();
    do_reset();
    // R1: idle after reset
    step(0, 0, "R1");
    step(0, 1, "R1");

    // R5: fixed vector, explicit expectations on the length-3 copy
    do_reset();
    vin  = 14'b10010100010111;
    vexp = 14'b11111111000001;
    for (int k = 13; k >= 0; k--) begin
      step(1, vin[k], "R5");
      chk(int'(out0), int'(vexp[k]), "R5");
    end

    // R2: gaps with a toggling input neither count nor break a run
    do_reset();
    step(1, 0, "R2");
    for (int k = 0; k < 4; k++) step(0, k[0], "R2");
    step(1, 0, "R2");
    step(0, 1, "R2");
    step(1, 0, "R2");
    chk(int'(out0), 0, "R2");
    step(0, 1, "R2");
    chk(int'(out0), 0, "R2");

    // R4 / R9: runs broken one short of length 3
    do_reset();
    step(1, 0, "R4"); step(1, 0, "R9"); step(1, 1, "R4");
    chk(int'(out0), 1, "R4");
    step(1, 0, "R4"); step(1, 0, "R4"); step(1, 1, "R4");
    chk(int'(out0), 1, "R4");
    step(1, 1, "R9");
    chk(int'(out1), 1, "R9");

    // R7: long run saturates, then a full opposite run is still needed
    do_reset();
    for (int k = 0; k < 40; k++) step(1, 0, "R7");
    chk(int'(out0), 0, "R7");
    step(1, 1, "R7"); step(1, 1, "R7");
    chk(int'(out0), 0, "R7");
    step(1, 1, "R3");
    chk(int'(out0), 1, "R3");

    // R8: reset while confirmed level is 0
    for (int k = 0; k < 3; k++) step(1, 0, "R8");
    chk(int'(out0), 0, "R8");
    do_reset();
    step(0, 0, "R8");
    chk(int'(out0), 1, "R8");

    // R3: pseudo-random stream with random strobe
    lfsr = 16'hACE1;
    for (int k = 0; k < 3000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[3:2] != 2'b00, lfsr[0] ^ (lfsr[7] & lfsr[5]), "R3");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule